// File: doc/BRIEF.md
# Exclusive Access Monitor for a Single-Master AXI3 Slave Port

This block sits beside an AXI3 slave port that one master uses. It watches the read and write address channels and the read and write response channels. It gives the master the load-exclusive / store-exclusive semantics that a plain memory slave cannot provide by itself. An access counts as exclusive when the lock bit is high on its address channel.

An exclusive read makes a reservation: a valid flag, an address and a size. A later exclusive write to exactly that address and size succeeds if no other write has touched the reserved bytes in between. A successful write goes to the slave unchanged and its write response is raised to exclusive-okay. A failed write has every write strobe forced low, so memory keeps its value, and the master receives a plain okay. The master's store-exclusive then reports failure.

Every exclusive write ends the reservation, whatever its outcome. The block supports one master only, so there is no input for clearing the reservation from software. The block assumes these usage rules:
- at most one read and one write are outstanding at a time;
- each burst is a single beat;
- every access is aligned to its size.

Top module: `axi_excl_monitor`

## Requirements
- R1: After reset no reservation exists: an exclusive write (lock high at the write address handshake) gets all strobes forced to 0 and a write response of 2'b00.
- R2: An exclusive read records its address and size, and a slave read response of 2'b00 on it is returned to the master as 2'b01.
- R3: Non-exclusive reads and writes pass their strobes and responses through unchanged.
- R4: An exclusive write whose address and size both equal a valid reservation passes its strobes unchanged, and a slave response of 2'b00 is returned as 2'b01.
- R5: An exclusive write whose address or size differs from the reservation fails: its strobes are forced to 0 and its response is 2'b00.
- R6: A non-exclusive write whose byte range [addr, addr+2^size) overlaps the reserved byte range clears the reservation. A non-overlapping one leaves the reservation intact.
- R7: Every exclusive write, successful or not, clears the reservation, so a second exclusive write to the same place fails.
- R8: A new exclusive read replaces the earlier reservation.
- R9: When an exclusive read handshake and a write handshake occur in the same cycle, the write is judged against the earlier reservation, and the read's new reservation survives that write.
- R10: Slave responses with bit 1 set (2'b10, 2'b11) reach the master unchanged on both the read and the write response channels, exclusive or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready from slave |
| ar_addr | input | ADDR_W | Read address |
| ar_size | input | 3 | Read size, log2 of bytes |
| ar_lock | input | 1 | Read is exclusive |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready from master |
| r_resp_slv | input | 2 | Read response from slave |
| r_resp_mst | output | 2 | Read response toward master |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready from slave |
| aw_addr | input | ADDR_W | Write address |
| aw_size | input | 3 | Write size, log2 of bytes |
| aw_lock | input | 1 | Write is exclusive |
| w_strb_in | input | LANES | Write strobes from master |
| w_strb_out | output | LANES | Gated write strobes toward slave |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready from master |
| b_resp_slv | input | 2 | Write response from slave |
| b_resp_mst | output | 2 | Write response toward master |

## Verification
A reservation that stays set when it should have been dropped shows as nonzero strobes and a 2'b01 response on the next exclusive write. A reservation that was lost shows as zeroed strobes and a 2'b00 response. A wrong verdict appears on the strobes in the same cycle as the write address handshake, and on the write response one cycle later. The bench sweeps reservation sizes and addresses against every aligned intervening write in a small window, so a wrong overlap boundary appears as an unexpected verdict on the exclusive write that follows.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_EXOKAY = 2'b01,
        RSP_SLVERR = 2'b10,
        RSP_DECERR = 2'b11
    } axi_rsp_e;

    typedef struct packed {
        logic excl;   // the write is exclusive
        logic pass;   // exclusive write succeeded
    } wr_verdict_t;

    function automatic logic [2:0] size_max(input logic [2:0] a, input logic [2:0] b);
        return (a > b) ? a : b;
    endfunction

    // Raise an okay on a successful exclusive access; keep error codes as they are.
    function automatic logic [1:0] rsp_remap(input logic excl, input logic pass,
                                             input logic [1:0] slv);
        logic [1:0] r;
        r = slv;
        if (slv == RSP_OKAY && excl && pass) r = RSP_EXOKAY;
        else if (slv == RSP_OKAY)            r = RSP_OKAY;
        return r;
    endfunction

endpackage

// File: rtl/excl_resv_store.sv
module excl_resv_store
    import excl_mon_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ar_fire,
    input  logic              ar_lock,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [2:0]        ar_size,
    input  logic              aw_fire,
    input  logic              aw_lock,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [2:0]        aw_size,
    output wr_verdict_t       verdict
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        size;
    } resv_t;

    resv_t resv_q, resv_d;
    logic [2:0]        span;
    logic [ADDR_W-1:0] hi_mask;
    logic              overlap;
    logic              exact;

    // Aligned ranges overlap when they agree above the larger size.
    always_comb begin
        span    = size_max(aw_size, resv_q.size);
        hi_mask = {ADDR_W{1'b1}} << span;
        overlap = resv_q.valid && (((aw_addr ^ resv_q.addr) & hi_mask) == '0);
        exact   = resv_q.valid && (aw_addr == resv_q.addr) && (aw_size == resv_q.size);
    end

    always_comb begin
        verdict.excl = aw_lock;
        verdict.pass = aw_lock ? exact : 1'b1;
    end

    always_comb begin
        resv_d = resv_q;
        if (aw_fire && (aw_lock || overlap)) resv_d.valid = 1'b0;
        // A read in the same cycle is ordered after the write.
        if (ar_fire && ar_lock) begin
            resv_d.valid = 1'b1;
            resv_d.addr  = ar_addr;
            resv_d.size  = ar_size;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) resv_q <= '0;
        else     resv_q <= resv_d;
    end
endmodule

// File: rtl/excl_resp_map.sv
module excl_resp_map
    import excl_mon_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ar_fire,
    input  logic        ar_lock,
    input  logic        r_fire,
    input  logic [1:0]  r_resp_slv,
    output logic [1:0]  r_resp_mst,
    input  logic        aw_fire,
    input  wr_verdict_t verdict_now,
    input  logic        b_fire,
    input  logic [1:0]  b_resp_slv,
    output logic [1:0]  b_resp_mst,
    output wr_verdict_t verdict_live
);
    logic        rd_excl_q;
    wr_verdict_t wr_pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_excl_q <= 1'b0;
        end else if (ar_fire) begin
            rd_excl_q <= ar_lock;
        end else if (r_fire) begin
            rd_excl_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pend_q <= '0;
        end else if (aw_fire) begin
            wr_pend_q <= verdict_now;
        end else if (b_fire) begin
            wr_pend_q <= '0;
        end
    end

    // Write data may share the address cycle, so the fresh verdict is used then.
    assign verdict_live = aw_fire ? verdict_now : wr_pend_q;

    assign r_resp_mst = rsp_remap(rd_excl_q, 1'b1, r_resp_slv);
    assign b_resp_mst = rsp_remap(wr_pend_q.excl, wr_pend_q.pass, b_resp_slv);
endmodule

// File: rtl/excl_strb_gate.sv
module excl_strb_gate
    import excl_mon_pkg::*;
#(
    parameter int LANES = 4
) (
    input  wr_verdict_t      verdict,
    input  logic [LANES-1:0] strb_in,
    output logic [LANES-1:0] strb_out
);
    logic kill;
    assign kill = verdict.excl && !verdict.pass;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign strb_out[i] = strb_in[i] && !kill;
    end
endmodule

// File: rtl/axi_excl_monitor.sv
module axi_excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ar_valid,
    input  logic              ar_ready,
    input  logic [ADDR_W-1:0] ar_addr,
    input  logic [2:0]        ar_size,
    input  logic              ar_lock,
    input  logic              r_valid,
    input  logic              r_ready,
    input  logic [1:0]        r_resp_slv,
    output logic [1:0]        r_resp_mst,
    input  logic              aw_valid,
    input  logic              aw_ready,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [2:0]        aw_size,
    input  logic              aw_lock,
    input  logic [LANES-1:0]  w_strb_in,
    output logic [LANES-1:0]  w_strb_out,
    input  logic              b_valid,
    input  logic              b_ready,
    input  logic [1:0]        b_resp_slv,
    output logic [1:0]        b_resp_mst
);
    logic        ar_fire, aw_fire, r_fire, b_fire;
    wr_verdict_t verdict_now, verdict_live;

    assign ar_fire = ar_valid && ar_ready;
    assign aw_fire = aw_valid && aw_ready;
    assign r_fire  = r_valid && r_ready;
    assign b_fire  = b_valid && b_ready;

    excl_resv_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst(rst),
        .ar_fire(ar_fire), .ar_lock(ar_lock), .ar_addr(ar_addr), .ar_size(ar_size),
        .aw_fire(aw_fire), .aw_lock(aw_lock), .aw_addr(aw_addr), .aw_size(aw_size),
        .verdict(verdict_now)
    );

    excl_resp_map u_map (
        .clk(clk), .rst(rst),
        .ar_fire(ar_fire), .ar_lock(ar_lock),
        .r_fire(r_fire), .r_resp_slv(r_resp_slv), .r_resp_mst(r_resp_mst),
        .aw_fire(aw_fire), .verdict_now(verdict_now),
        .b_fire(b_fire), .b_resp_slv(b_resp_slv), .b_resp_mst(b_resp_mst),
        .verdict_live(verdict_live)
    );

    excl_strb_gate #(.LANES(LANES)) u_gate (
        .verdict(verdict_live), .strb_in(w_strb_in), .strb_out(w_strb_out)
    );
endmodule

// File: rtl/excl_mon_checker.sv
module excl_mon_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ar_valid,
    input logic             ar_ready,
    input logic             ar_lock,
    input logic             r_valid,
    input logic [1:0]       r_resp_slv,
    input logic [1:0]       r_resp_mst,
    input logic             aw_valid,
    input logic             aw_ready,
    input logic             aw_lock,
    input logic [LANES-1:0] w_strb_in,
    input logic [LANES-1:0] w_strb_out,
    input logic             b_valid,
    input logic [1:0]       b_resp_slv,
    input logic [1:0]       b_resp_mst
);
    logic no_resv;      // no exclusive read since reset or the last exclusive write
    logic last_aw_excl;

    always_ff @(posedge clk) begin
        if (rst) begin
            no_resv      <= 1'b1;
            last_aw_excl <= 1'b0;
        end else begin
            if (aw_valid && aw_ready) begin
                last_aw_excl <= aw_lock;
                if (aw_lock) no_resv <= 1'b1;
            end
            if (ar_valid && ar_ready && ar_lock) no_resv <= 1'b0;
        end
    end

    // R1 R7: without a reservation an exclusive write must be blocked
    p_no_resv_block_r7: assert property (@(posedge clk) disable iff (rst)
        (no_resv && aw_valid && aw_ready && aw_lock) |-> (w_strb_out == '0));

    p_exok_only_excl_r4: assert property (@(posedge clk) disable iff (rst)
        (b_valid && b_resp_mst == 2'b01) |-> last_aw_excl);

    p_norm_strb_r3: assert property (@(posedge clk) disable iff (rst)
        (aw_valid && aw_ready && !aw_lock) |-> (w_strb_out == w_strb_in));

    p_berr_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (b_valid && b_resp_slv[1]) |-> (b_resp_mst == b_resp_slv));

    p_rerr_pass_r10: assert property (@(posedge clk) disable iff (rst)
        (r_valid && r_resp_slv[1]) |-> (r_resp_mst == r_resp_slv));
endmodule

bind axi_excl_monitor excl_mon_checker #(.LANES(LANES)) u_chk (
    .clk(clk), .rst(rst),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_lock(ar_lock),
    .r_valid(r_valid), .r_resp_slv(r_resp_slv), .r_resp_mst(r_resp_mst),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_lock(aw_lock),
    .w_strb_in(w_strb_in), .w_strb_out(w_strb_out),
    .b_valid(b_valid), .b_resp_slv(b_resp_slv), .b_resp_mst(b_resp_mst)
);

// File: tb/axi_excl_monitor_bench.sv
`timescale 1ns/1ps
module axi_excl_monitor_bench;
    localparam int ADDR_W = 16;
    localparam int LANES  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ar_valid = 0, ar_ready = 0, ar_lock = 0;
    logic [ADDR_W-1:0] ar_addr = '0;
    logic [2:0] ar_size = '0;
    logic r_valid = 0, r_ready = 0;
    logic [1:0] r_resp_slv = '0, r_resp_mst;
    logic aw_valid = 0, aw_ready = 0, aw_lock = 0;
    logic [ADDR_W-1:0] aw_addr = '0;
    logic [2:0] aw_size = '0;
    logic [LANES-1:0] w_strb_in = '0, w_strb_out;
    logic b_valid = 0, b_ready = 0;
    logic [1:0] b_resp_slv = '0, b_resp_mst;

    always #2.5 clk = ~clk;

    axi_excl_monitor #(.ADDR_W(ADDR_W), .LANES(LANES)) u_axi_excl_monitor (.*);

    int n_cmp = 0, n_bad = 0;
    // bench reservation model
    bit m_valid = 0;
    int m_addr = 0, m_size = 0;

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic bit ranges_meet(int a, int s, int b, int t);
        return (a < b + (1 << t)) && (b < a + (1 << s));
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        m_valid = 0;
    endtask

    task automatic rd(input int addr, input int size, input bit lock,
                      input logic [1:0] slv, input string tag);
        int exp;
        ar_valid = 1; ar_ready = 1; ar_addr = addr[ADDR_W-1:0];
        ar_size = size[2:0]; ar_lock = lock;
        @(negedge clk);
        ar_valid = 0; ar_ready = 0;
        r_valid = 1; r_ready = 1; r_resp_slv = slv;
        #1;
        exp = (slv == 2'b00 && lock) ? 1 : int'(slv);
        check(tag, int'(r_resp_mst), exp);
        if (lock) begin m_valid = 1; m_addr = addr; m_size = size; end
        @(negedge clk);
        r_valid = 0; r_ready = 0;
    endtask

    // also_ar: issue an exclusive read at (ra, rs) in the same cycle
    task automatic wr(input int addr, input int size, input bit lock,
                      input logic [3:0] strb, input logic [1:0] slv,
                      input string tag, input bit also_ar = 0,
                      input int ra = 0, input int rs = 0);
        bit pass;
        int exp;
        pass = lock ? (m_valid && addr == m_addr && size == m_size) : 1'b1;
        aw_valid = 1; aw_ready = 1; aw_addr = addr[ADDR_W-1:0];
        aw_size = size[2:0]; aw_lock = lock; w_strb_in = strb;
        if (also_ar) begin
            ar_valid = 1; ar_ready = 1; ar_addr = ra[ADDR_W-1:0];
            ar_size = rs[2:0]; ar_lock = 1;
        end
        #1;
        check({tag, " strb"}, int'(w_strb_out), pass ? int'(strb) : 0);
        if (lock) m_valid = 0;
        else if (m_valid && ranges_meet(addr, size, m_addr, m_size)) m_valid = 0;
        if (also_ar) begin m_valid = 1; m_addr = ra; m_size = rs; end
        @(negedge clk);
        aw_valid = 0; aw_ready = 0; ar_valid = 0; ar_ready = 0;
        b_valid = 1; b_ready = 1; b_resp_slv = slv;
        #1;
        if (slv != 2'b00) exp = int'(slv);
        else exp = (lock && pass) ? 1 : 0;
        check({tag, " bresp"}, int'(b_resp_mst), exp);
        @(negedge clk);
        b_valid = 0; b_ready = 0;
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check("R1 idle bresp", int'(b_resp_mst), 0);
        check("R1 idle rresp", int'(r_resp_mst), 0);
        // R1: first exclusive write after reset fails
        wr(0, 2, 1, 4'hF, 2'b00, "R1");

        // R6 / R4 / R2: reservation sizes and places against every aligned normal write
        for (int rs = 0; rs < 3; rs++) begin
            for (int ri = 0; ri < 4; ri++) begin
                int ra;
                ra = 8 + ri * (1 << rs);
                for (int ws = 0; ws < 3; ws++) begin
                    for (int wa = 0; wa < 32; wa += (1 << ws)) begin
                        rd(ra, rs, 1, 2'b00, "R2");
                        wr(wa, ws, 0, 4'b1011, 2'b00, "R3");
                        wr(ra, rs, 1, 4'b0110,
                           2'b00, ranges_meet(wa, ws, ra, rs) ? "R6" : "R4");
                    end
                end
            end
        end

        // R5: address or size mismatch
        for (int s = 0; s < 3; s++) begin
            for (int a = 0; a < 32; a += (1 << s)) begin
                rd(16, 2, 1, 2'b00, "R2");
                wr(a, s, 1, 4'hF, 2'b00, (a == 16 && s == 2) ? "R4" : "R5");
            end
        end

        // R7: exclusive write always consumes the reservation
        rd(40, 2, 1, 2'b00, "R2");
        wr(40, 2, 1, 4'hF, 2'b00, "R7 first");
        wr(40, 2, 1, 4'hF, 2'b00, "R7 second");
        rd(44, 1, 1, 2'b00, "R2");
        wr(46, 1, 1, 4'hC, 2'b00, "R7 mismatch");
        wr(44, 1, 1, 4'hC, 2'b00, "R7 after fail");

        // R8: newer exclusive read replaces the reservation
        rd(48, 2, 1, 2'b00, "R2");
        rd(52, 2, 1, 2'b00, "R2");
        wr(48, 2, 1, 4'hF, 2'b00, "R8 old");
        rd(48, 2, 1, 2'b00, "R2");
        rd(52, 2, 1, 2'b00, "R2");
        wr(52, 2, 1, 4'hF, 2'b00, "R8 new");

        // R3: a normal read does not disturb the reservation
        rd(60, 2, 1, 2'b00, "R2");
        rd(60, 2, 0, 2'b00, "R3 read");
        wr(60, 2, 1, 4'hF, 2'b00, "R3 keep");

        // R9: same-cycle exclusive read and write
        rd(64, 2, 1, 2'b00, "R2");
        wr(64, 2, 1, 4'hF, 2'b00, "R9 old", 1, 68, 2);
        wr(68, 2, 1, 4'hF, 2'b00, "R9 new");
        rd(72, 2, 1, 2'b00, "R2");
        wr(80, 2, 0, 4'hF, 2'b00, "R9 normal", 1, 80, 2);
        wr(80, 2, 1, 4'hF, 2'b00, "R9 survive");

        // R10: error codes pass through
        rd(84, 2, 1, 2'b10, "R10 rd");
        rd(84, 2, 0, 2'b11, "R10 rd");
        wr(84, 2, 1, 4'hF, 2'b10, "R10 wr");
        wr(88, 2, 0, 4'hF, 2'b11, "R10 wr");

        // R1: mid-run reset drops a live reservation
        rd(92, 2, 1, 2'b00, "R2");
        do_reset();
        wr(92, 2, 1, 4'hF, 2'b00, "R1 reset");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule